// File: doc/BRIEF.md
# Serial SRAM Target Engine

This block is the device side of a byte-wide serial static memory. A host selects it by pulling chip select low. The host then sends an 8-bit command and, for array accesses, a 24-bit address. After that, data bytes stream into the internal array or out of it until chip select returns high. Every field travels most significant bit first. Input bits are taken on the rising serial clock. Output bits are updated after the falling serial clock.

An 8-bit mode register sets how the internal address pointer behaves across a burst:
- A single-byte mode that allows one byte per access.
- A page mode that wraps inside an aligned 32-byte page.
- A sequential mode that runs through the whole array and rolls over to zero.

A second pair of commands moves the link between one-lane and two-lane transfer. In two-lane transfer, each clock carries two bits, and every read returns one filler byte before the first data byte.

The serial pins (`sck`, `cs_n`, the two lanes) are oversampled by the block clock `clk`. The lanes are split into input values, output values and per-lane output enables, so the pad ring can build the bidirectional pins. The array width is the parameter `ARRAY_AW`. A full-size build sets it to 17. The default of 10 keeps the stand-in register array small.

Top module: `sram_spi_target`

## Requirements
- R1: After reset, nothing is accepted until chip select goes from high to low. If chip select is already low when reset is released, the clocks of that transaction are ignored: the mode register is unchanged and both lane enables stay low.
- R2: In one-lane transfer, command 0x02 followed by an address writes the bytes that follow. Command 0x03 followed by an address returns the stored bytes on lane 1. All fields are MSB first. Inputs are taken on rising clocks. Each output bit appears after the falling clock that ends the previous bit, so the first data bit is driven after the falling clock of the last address bit.
- R3: Only the low `ARRAY_AW` bits of the 24-bit address select a byte. The higher address bits have no effect.
- R4: Chip select going high ends any access. Both lane enables go low. A write byte that was not fully received is discarded.
- R5: Command 0x05 returns the mode register on the next byte. Bits 7:6 hold the burst mode and bits 5:0 read as zero. After reset the value is 0x40 (sequential).
- R6: Command 0x01 loads bits 7:6 of the next byte into the mode register and discards bits 5:0.
- R7: With mode bits 01 (or 11), the pointer advances by one after each byte and rolls over from the last array byte to address 0.
- R8: With mode bits 10, the pointer advances by one but wraps within its aligned 32-byte page.
- R9: With mode bits 00, only the first data byte of an access is transferred. Further write bytes are dropped. On further read clocks both lanes are released.
- R10: Command 0x3B switches the link to two-lane transfer from the next transaction onward. Each clock then carries two bits: lane 1 takes the higher bit and lane 0 the lower bit, with the top pair first, so one byte takes 4 clocks.
- R11: In two-lane transfer, a read leaves both lanes released for one filler byte (4 clocks) after the address. It then drives both lanes with the data.
- R12: Only command 0xFF, sent in the lane format currently active (all ones on both lanes in two-lane transfer), returns the link to one-lane transfer. Other commands leave the lane format unchanged.
- R13: Any other command code is ignored until the next selection. Both lanes stay released, and neither the array nor the mode register changes.
- R14: In one-lane transfer only lane 1 is ever driven. Lane 0 is never driven alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sio_in | input | 2 | Values seen on the lanes; bit 0 is the serial input in one-lane transfer |
| sio_out | output | 2 | Values driven on the lanes |
| sio_oe | output | 2 | Per-lane output enable; low means high impedance |

## Verification
The bench targets four groups of corner cases. Each lists what a faulty design would do.
- **Pointer rollover and page wrap.** A design with the wrong wrap would write over the wrong neighbour or read back stale bytes at the array end and the page edge.
- **The single-byte mode.** A design that did not stop after one byte would overwrite the prepared bytes behind the first one, or keep driving on the following read clocks.
- **The two-lane filler byte.** An off-by-one in the filler count would shift every read byte by a pair of bits or drive the lanes during the filler.
- **Guards.** These cover the selection that is open when reset is released, the partial byte cut short by chip select, and the unknown command code. A design that missed any of these would change the mode register or the array when it should not.

The bench also runs a randomised mix of writes, reads and mode changes in both lane formats against its own model of the array.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_RDAT,
    PH_WDAT,
    PH_MRD,
    PH_MWR,
    PH_IDLE
  } phase_t;

  typedef enum logic [1:0] {
    BURST_ONE  = 2'b00,
    BURST_RUN  = 2'b01,
    BURST_WRAP = 2'b10,
    BURST_RSV  = 2'b11
  } burst_t;

  localparam logic [7:0] OP_READ     = 8'h03;
  localparam logic [7:0] OP_WRITE    = 8'h02;
  localparam logic [7:0] OP_DUAL_ON  = 8'h3B;
  localparam logic [7:0] OP_DUAL_OFF = 8'hFF;
  localparam logic [7:0] OP_MODE_RD  = 8'h05;
  localparam logic [7:0] OP_MODE_WR  = 8'h01;

  // Append one (lane 0) or two (lane 1 high, lane 0 low) received bits.
  function automatic logic [23:0] shift_in(logic [23:0] cur, logic [1:0] lanes, logic dual);
    return dual ? {cur[21:0], lanes} : {cur[22:0], lanes[0]};
  endfunction

  // Lane values for the top of a byte; one-lane output uses lane 1 only.
  function automatic logic [1:0] lane_pick(logic [7:0] b, logic dual);
    return dual ? b[7:6] : {b[7], 1'b0};
  endfunction

  // Phase entered once a full command byte has arrived.
  function automatic phase_t decode(logic [7:0] op);
    case (op)
      OP_READ, OP_WRITE: return PH_ADDR;
      OP_MODE_RD:        return PH_MRD;
      OP_MODE_WR:        return PH_MWR;
      default:           return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/sram_spi_pins.sv
module sram_spi_pins (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic [1:0] sio_in,
  output logic       sck_rise,
  output logic       sck_fall,
  output logic       sel_start,
  output logic       sel_idle,
  output logic [1:0] lanes
);
  logic [1:0] sck_r;
  logic [1:0] cs_r;
  logic [1:0] din_r;

  // cs_r resets to "low" so a select already active at reset is no start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_r <= 2'b00;
      cs_r  <= 2'b00;
      din_r <= 2'b00;
    end else begin
      sck_r <= {sck_r[0], sck};
      cs_r  <= {cs_r[0], cs_n};
      din_r <= sio_in;
    end
  end

  assign sck_rise  = sck_r[0] & ~sck_r[1];
  assign sck_fall  = ~sck_r[0] & sck_r[1];
  assign sel_start = ~cs_r[0] & cs_r[1];
  assign sel_idle  = cs_r[0];
  assign lanes     = din_r;
endmodule

// File: rtl/sram_spi_array.sv
module sram_spi_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wr_data;
  end

  assign rd_data = cells[addr];
endmodule

// File: rtl/sram_spi_ctrl.sv
module sram_spi_ctrl
  import sram_spi_pkg::*;
#(
  parameter int AW         = 10,
  parameter int PAGE_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          sel_start,
  input  logic          sel_idle,
  input  logic [1:0]    lanes,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ptr_o,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic [1:0]    sio_out,
  output logic [1:0]    sio_oe,
  output logic          dual_o,
  output logic [1:0]    mode_o,
  output logic          cmd_done
);
  localparam logic [AW-1:0] PAGE_MASK = AW'(PAGE_BYTES - 1);
  localparam logic [4:0]    BYTE_BITS = 5'd8;
  localparam logic [4:0]    ADDR_BITS = 5'd24;

  // Pointer step after one byte, for the given burst mode.
  function automatic logic [AW-1:0] advance(logic [AW-1:0] p, burst_t m);
    logic [AW-1:0] inc;
    inc = p + 1'b1;
    if (m == BURST_WRAP) return (p & ~PAGE_MASK) | (inc & PAGE_MASK);
    return inc;
  endfunction

  logic          active;
  phase_t        phase;
  burst_t        mode;
  logic          dual;
  logic          is_read;
  logic [4:0]    bcnt;
  logic [23:0]   rx_sh;
  logic [AW-1:0] ptr;
  logic [7:0]    tx_sh;
  logic [2:0]    tx_pos;
  logic [1:0]    out_q;
  logic          drive;
  logic          once;
  logic [1:0]    dcnt;

  logic [23:0] rx_next;
  logic [4:0]  cnt_next;
  logic [2:0]  step;
  logic        live;
  logic        byte_full;
  logic [7:0]  src;

  assign rx_next   = shift_in(rx_sh, lanes, dual);
  assign step      = dual ? 3'd2 : 3'd1;
  assign cnt_next  = bcnt + {2'b00, step};
  assign live      = active & ~sel_idle;
  assign byte_full = (cnt_next == BYTE_BITS);
  assign src       = (phase == PH_MRD) ? {mode, 6'b000000} : rd_data;

  assign cmd_done = live & sck_rise & (phase == PH_CMD) & byte_full;
  assign wr_en    = live & sck_rise & (phase == PH_WDAT) & byte_full;
  assign wr_data  = rx_next[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      phase   <= PH_CMD;
      mode    <= BURST_RUN;
      dual    <= 1'b0;
      is_read <= 1'b0;
      bcnt    <= '0;
      rx_sh   <= '0;
      ptr     <= '0;
      tx_sh   <= '0;
      tx_pos  <= '0;
      out_q   <= '0;
      drive   <= 1'b0;
      once    <= 1'b0;
      dcnt    <= '0;
    end else if (!live) begin
      if (sel_idle) active <= 1'b0;
      else if (sel_start) active <= 1'b1;
      phase  <= PH_CMD;
      bcnt   <= '0;
      tx_pos <= '0;
      drive  <= 1'b0;
      once   <= 1'b0;
      dcnt   <= '0;
    end else if (sck_rise) begin
      case (phase)
        PH_CMD: begin
          rx_sh <= rx_next;
          if (byte_full) begin
            bcnt    <= '0;
            phase   <= decode(rx_next[7:0]);
            is_read <= (rx_next[7:0] == OP_READ);
            if (rx_next[7:0] == OP_DUAL_ON) dual <= 1'b1;
            if (rx_next[7:0] == OP_DUAL_OFF) dual <= 1'b0;
          end else begin
            bcnt <= cnt_next;
          end
        end
        PH_ADDR: begin
          rx_sh <= rx_next;
          if (cnt_next == ADDR_BITS) begin
            bcnt  <= '0;
            ptr   <= rx_next[AW-1:0];
            phase <= !is_read ? PH_WDAT : (dual ? PH_DUMMY : PH_RDAT);
          end else begin
            bcnt <= cnt_next;
          end
        end
        PH_WDAT: begin
          rx_sh <= rx_next;
          if (byte_full) begin
            bcnt <= '0;
            ptr  <= advance(ptr, mode);
            if (mode == BURST_ONE) phase <= PH_IDLE;
          end else begin
            bcnt <= cnt_next;
          end
        end
        PH_MWR: begin
          rx_sh <= rx_next;
          if (byte_full) begin
            mode  <= burst_t'(rx_next[7:6]);
            phase <= PH_IDLE;
          end else begin
            bcnt <= cnt_next;
          end
        end
        default: ;
      endcase
    end else if (sck_fall) begin
      case (phase)
        PH_DUMMY: begin
          dcnt <= dcnt + 2'd1;
          if (dcnt == 2'd3) phase <= PH_RDAT;
        end
        PH_RDAT, PH_MRD: begin
          if (tx_pos == 3'd0) begin
            if (once) begin
              drive <= 1'b0;
              phase <= PH_IDLE;
            end else begin
              out_q  <= lane_pick(src, dual);
              tx_sh  <= dual ? {src[5:0], 2'b00} : {src[6:0], 1'b0};
              tx_pos <= step;
              drive  <= 1'b1;
              if (phase == PH_RDAT) begin
                ptr  <= advance(ptr, mode);
                once <= (mode == BURST_ONE);
              end
            end
          end else begin
            out_q  <= lane_pick(tx_sh, dual);
            tx_sh  <= dual ? {tx_sh[5:0], 2'b00} : {tx_sh[6:0], 1'b0};
            tx_pos <= tx_pos + step;
          end
        end
        default: ;
      endcase
    end
  end

  assign ptr_o   = ptr;
  assign sio_out = out_q;
  assign sio_oe  = drive ? (dual ? 2'b11 : 2'b10) : 2'b00;
  assign dual_o  = dual;
  assign mode_o  = mode;
endmodule

// File: rtl/sram_spi_target.sv
module sram_spi_target #(
  parameter int ARRAY_AW   = 10,
  parameter int PAGE_BYTES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic [1:0] sio_in,
  output logic [1:0] sio_out,
  output logic [1:0] sio_oe
);
  logic                sck_rise;
  logic                sck_fall;
  logic                sel_start;
  logic                sel_idle;
  logic [1:0]          lanes;
  logic [ARRAY_AW-1:0] ptr;
  logic                wr_en;
  logic [7:0]          wr_data;
  logic [7:0]          rd_data;
  logic                dual;
  logic [1:0]          mode;
  logic                cmd_done;

  sram_spi_pins pins_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sio_in(sio_in),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sel_start(sel_start),
    .sel_idle(sel_idle), .lanes(lanes)
  );

  sram_spi_ctrl #(.AW(ARRAY_AW), .PAGE_BYTES(PAGE_BYTES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel_start(sel_start), .sel_idle(sel_idle), .lanes(lanes),
    .rd_data(rd_data), .ptr_o(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .sio_out(sio_out), .sio_oe(sio_oe), .dual_o(dual), .mode_o(mode),
    .cmd_done(cmd_done)
  );

  sram_spi_array #(.AW(ARRAY_AW)) array_i (
    .clk(clk), .wr_en(wr_en), .addr(ptr), .wr_data(wr_data), .rd_data(rd_data)
  );
endmodule

// File: rtl/sram_spi_target_chk.sv
module sram_spi_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck_rise,
  input logic       sck_fall,
  input logic       sel_idle,
  input logic       wr_en,
  input logic       cmd_done,
  input logic       dual,
  input logic [1:0] mode,
  input logic [1:0] sio_out,
  input logic [1:0] sio_oe
);
  // R4
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_idle && $past(sel_idle)) |-> (sio_oe == 2'b00));

  // R14
  lane0_dual_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sio_oe[0] |-> dual);

  // R14
  lane0_never_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sio_oe != 2'b01);

  // R2
  write_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (sck_rise && !sel_idle));

  // R2
  out_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sck_fall) |-> $stable(sio_out));

  // R6
  mode_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> $past(sck_rise));

  // R12
  dual_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dual) |-> $past(cmd_done));
endmodule

bind sram_spi_target sram_spi_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
  .sel_idle(sel_idle), .wr_en(wr_en), .cmd_done(cmd_done), .dual(dual),
  .mode(mode), .sio_out(sio_out), .sio_oe(sio_oe)
);

// File: tb/sram_spi_target_tb_top.sv
module sram_spi_target_tb_top;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       cs_n = 1'b0;
  logic [1:0] sio_in = 2'b00;
  logic [1:0] sio_out;
  logic [1:0] sio_oe;

  always #2 clk = ~clk;

  sram_spi_target #(.ARRAY_AW(AW), .PAGE_BYTES(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe)
  );

  int         checks = 0;
  int         errors = 0;
  logic [7:0] mem_m [DEPTH];
  bit         vld [DEPTH];
  logic [1:0] m_mode = 2'b01;
  bit         dual_m = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rb;
  logic [1:0] oor;
  logic [1:0] oand;

  function automatic logic [AW-1:0] bnext(logic [AW-1:0] a, logic [1:0] m);
    if (m == 2'b10) return {a[AW-1:5], 5'(a[4:0] + 5'd1)};
    return a + 1'b1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xf(input logic [7:0] b, input int nclk);
    logic [7:0] sh;
    sh = b; rb = 8'h00; oor = 2'b00; oand = 2'b11;
    for (int i = 0; i < nclk; i++) begin
      sio_in = dual_m ? sh[7:6] : {1'b0, sh[7]};
      sh = dual_m ? {sh[5:0], 2'b00} : {sh[6:0], 1'b0};
      repeat (4) @(negedge clk);
      rb = dual_m ? {rb[5:0], sio_out} : {rb[6:0], sio_out[1]};
      oor = oor | sio_oe;
      oand = oand & sio_oe;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic put(input logic [7:0] b);
    xf(b, dual_m ? 4 : 8);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic desel();
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_write(input logic [23:0] a24, input int n);
    logic [AW-1:0] a;
    a = a24[AW-1:0];
    sel();
    put(8'h02); put(a24[23:16]); put(a24[15:8]); put(a24[7:0]);
    for (int i = 0; i < n; i++) begin
      put(wbuf[i]);
      if (!(m_mode == 2'b00 && i > 0)) begin
        mem_m[a] = wbuf[i];
        vld[a] = 1'b1;
        a = bnext(a, m_mode);
      end
    end
    desel();
  endtask

  task automatic do_read(input logic [23:0] a24, input int n, input string req);
    logic [AW-1:0] a;
    a = a24[AW-1:0];
    sel();
    put(8'h03); put(a24[23:16]); put(a24[15:8]); put(a24[7:0]);
    if (dual_m) begin
      xf(8'h00, 4);
      check("R11 filler byte lanes released", 32'(oor), 32'h0);
    end
    for (int i = 0; i < n; i++) begin
      put(8'h00);
      if (m_mode == 2'b00 && i > 0) begin
        check("R9 lanes released after single byte", 32'(oor), 32'h0);
      end else begin
        if (vld[a]) check(req, 32'(rb), 32'(mem_m[a]));
        if (dual_m) check("R11 both lanes driven", 32'({oor, oand}), 32'hF);
        else check("R14 only lane1 driven", 32'({oor, oand}), 32'hA);
        a = bnext(a, m_mode);
      end
    end
    desel();
  endtask

  task automatic mode_rd(input string req);
    sel();
    put(8'h05); put(8'h00);
    check(req, 32'(rb), 32'({m_mode, 6'b000000}));
    desel();
  endtask

  task automatic mode_wr(input logic [7:0] v);
    sel();
    put(8'h01); put(v);
    desel();
    m_mode = v[7:6];
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) vld[i] = 1'b0;

    // R1: chip select low while reset is released
    repeat (8) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 lanes released after reset", 32'(sio_oe), 32'h0);
    xf(8'h01, 8); xf(8'h00, 8);
    xf(8'h05, 8); xf(8'h00, 8);
    check("R1 no drive before first select", 32'(oor), 32'h0);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    mode_rd("R1 R5 mode still sequential 0x40");

    // R2: one-lane burst
    wbuf[0] = 8'h81; wbuf[1] = 8'h42; wbuf[2] = 8'h3C; wbuf[3] = 8'hE7;
    do_write(24'h000010, 4);
    do_read(24'h000010, 4, "R2 one-lane burst readback");

    // R3: high address bits ignored
    wbuf[0] = 8'h6D;
    do_write(24'hFFFC55, 1);
    do_read(24'h000055, 1, "R3 alias of high address bits");

    // R7: sequential rollover
    wbuf[0] = 8'h11; wbuf[1] = 8'h99; wbuf[2] = 8'h5E;
    do_write(24'h0003FF, 3);
    do_read(24'h0003FF, 3, "R7 rollover burst");
    do_read(24'h000000, 1, "R7 byte at address zero");

    // preparation for R4 and R9
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(24'h000100, 3);
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2;
    do_write(24'h000200, 2);

    // R4: partial byte discarded, release on deselect
    sel();
    put(8'h02); put(8'h00); put(8'h02); put(8'h00);
    put(8'h5A);
    xf(8'hC3, 5);
    desel();
    mem_m[10'h200] = 8'h5A;
    do_read(24'h000200, 2, "R4 partial byte not written");
    sel();
    put(8'h03); put(8'h00); put(8'h02); put(8'h00);
    xf(8'h00, 3);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R4 lanes released on deselect", 32'(sio_oe), 32'h0);

    // R6 and R8: page mode
    mode_wr(8'hBF);
    mode_rd("R6 low bits forced to zero");
    wbuf[0] = 8'hD0; wbuf[1] = 8'hD1; wbuf[2] = 8'hD2; wbuf[3] = 8'hD3;
    do_write(24'h00003E, 4);
    do_read(24'h00003E, 4, "R8 page wrap burst");
    do_read(24'h000020, 1, "R8 page start written by wrap");

    // R9: single-byte mode
    mode_wr(8'h00);
    mode_rd("R6 byte mode readback");
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
    do_write(24'h000100, 3);
    do_read(24'h000100, 3, "R9 first byte only");
    mode_wr(8'h40);
    do_read(24'h000100, 3, "R9 later bytes untouched");

    // R13: unknown command
    sel();
    put(8'hA5); put(8'h01); put(8'h00); put(8'h05);
    check("R13 no drive for unknown code", 32'(oor), 32'h0);
    desel();
    mode_rd("R13 mode unchanged");
    do_read(24'h000010, 2, "R13 array unchanged");

    // R10, R11, R12: two-lane transfer
    sel(); put(8'h3B); desel();
    dual_m = 1'b1;
    mode_rd("R10 mode read in two-lane format");
    for (int i = 0; i < 5; i++) wbuf[i] = 8'($urandom);
    do_write(24'h000080, 5);
    do_read(24'h000080, 5, "R10 two-lane burst readback");
    mode_wr(8'h80);
    mode_rd("R12 still two-lane after other commands");
    do_read(24'h00009F, 2, "R11 two-lane page wrap");
    mode_wr(8'h40);
    sel(); put(8'hFF); desel();
    dual_m = 1'b0;
    mode_rd("R12 back to one-lane");
    do_read(24'h000080, 2, "R12 one-lane read after exit");

    // random mix
    for (int t = 0; t < 40; t++) begin
      int k;
      int n;
      logic [23:0] a24;
      if (t % 10 == 9) begin
        sel(); put(dual_m ? 8'hFF : 8'h3B); desel();
        dual_m = ~dual_m;
      end
      k = $urandom % 8;
      n = 1 + ($urandom % 6);
      a24 = 24'($urandom);
      if (k < 3) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        do_write(a24, n);
      end else if (k < 6) begin
        do_read(a24, n, "R2 random read");
      end else if (k == 6) begin
        mode_rd("R5 random mode read");
      end else begin
        mode_wr(8'($urandom));
        mode_rd("R6 random mode write");
      end
    end

    summary();
    $finish;
  end
endmodule